// File: doc/BRIEF.md
# Four-Pointer Memory Address Unit

This unit keeps four 24-bit memory pointers for a processor datapath. Each pointer is split into three bytes: low, high and extension. Software reaches every byte through a byte-wide register port. A two-bit select field picks the active pointer. The active pointer drives the memory address output, and it is the only pointer that moves when the datapath pulses the step strobe.

Each pointer has its own direction flag, so one step command adds one to some pointers and subtracts one from others. The low select bit sits alone: the bit above it is absent, and the upper select bit is further up the control byte. Stepping that control byte, which the toggle strobe models, therefore swaps pointer 0 with 1, or pointer 2 with 3, and never crosses between the pairs.

A mode input chooses the address width. In narrow mode, which is the state after reset, only the low 16 bits of a pointer count and form the address. In wide mode all 24 bits are used.

Top module: `ptr_unit`

## Requirements
- R1: After reset every pointer byte, both select bits and all four direction flags are zero, so pointer 0 is active, counts upward, and `mem_addr` is 0.
- R2: Register address bits [3:2] pick a pointer and bits [1:0] pick a byte of it (0 low, 1 high, 2 extension). Byte code 3 reads as zero and ignores writes. Control byte A sits at 0x10 and control byte B at 0x11. Every other address reads zero and ignores writes.
- R3: When `wide_mode` is 1, `mem_addr` equals the full active pointer. When it is 0, `mem_addr` is the low 16 bits of the active pointer with bits [23:16] forced to zero.
- R4: A step with direction flag 0 adds one to the active pointer only. The carry ripples through all three bytes in wide mode, and 0xFFFFFF wraps to 0.
- R5: A step with direction flag 1 subtracts one from the active pointer. The borrow ripples through all three bytes in wide mode, and 0 wraps to 0xFFFFFF.
- R6: In narrow mode a step changes only the low 16 bits, which wrap modulo 2^16. The extension byte keeps its value.
- R7: Control byte A holds select bit 0 at bit 0, select bit 1 at bit 3, the direction flag of pointer 0 at bit 6 and that of pointer 1 at bit 7. Control byte B holds the direction flags of pointers 2 and 3 at bits 6 and 7. All other control bits read zero.
- R8: A toggle pulse inverts select bit 0 and leaves select bit 1 alone, so the active pointer alternates 0<->1 or 2<->3.
- R9: In any cycle with `wr_en` high, the step and toggle strobes have no effect. The register write alone updates the state.
- R10: When step and toggle arrive in the same cycle, the step applies to the pointer that was active before the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| step_stb | input | 1 | Step the active pointer by one in its direction |
| tog_stb | input | 1 | Invert select bit 0 |
| wide_mode | input | 1 | 1: 24-bit addressing, 0: 16-bit addressing |
| mem_addr | output | 24 | Address from the active pointer |

## Verification
The assertions assume that `wide_mode` is held steady around each step, so a step's effect can be compared with the pointer value one cycle earlier. The bench changes the mode only in cycles with no strobe. The step properties also exclude cycles in which a write or a toggle coincides with the step, because the active pointer is then not a single well-defined register. The bench drives those overlaps only in separate directed cases that check the result at the ports.

// File: rtl/ptr_unit_pkg.sv
package ptr_unit_pkg;
  localparam int BYTE_W   = 8;
  localparam int REG_AW   = 5;
  localparam logic [REG_AW-1:0] CTRL_A_ADDR = 5'h10;
  localparam logic [REG_AW-1:0] CTRL_B_ADDR = 5'h11;
  // control byte bit positions (the low select bit must have an empty neighbour)
  localparam int SEL0_BIT = 0;
  localparam int SEL1_BIT = 3;
  localparam int DIRL_BIT = 6;
  localparam int DIRH_BIT = 7;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ptr_slot.sv
module ptr_slot #(
  parameter int BYTE_W    = 8,
  parameter int NBYTES    = 3,
  parameter int LOW_BYTES = 2,
  localparam int PW    = BYTE_W*NBYTES,
  localparam int LW    = BYTE_W*LOW_BYTES,
  localparam int BSEL_W = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BSEL_W-1:0] wr_byte,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              step_en,
  input  logic              dir_dn,
  input  logic              wide,
  output logic [PW-1:0]     value
);
  logic [PW-1:0] cur_q, nxt;
  logic          ld;

  always_comb begin
    nxt = cur_q;
    ld  = 1'b0;
    if (wr_en) begin
      nxt[int'(wr_byte)*BYTE_W +: BYTE_W] = wr_data;
      ld = 1'b1;
    end else if (step_en) begin
      ld = 1'b1;
      if (wide)
        nxt = dir_dn ? cur_q - PW'(1) : cur_q + PW'(1);
      else
        nxt[LW-1:0] = dir_dn ? cur_q[LW-1:0] - LW'(1) : cur_q[LW-1:0] + LW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cur_q <= '0;
    else if (ld) cur_q <= nxt;
  end

  assign value = cur_q;
endmodule

// File: rtl/ptr_ctrl.sv
module ptr_ctrl
  import ptr_unit_pkg::*;
#(
  parameter int NUM_PTR = 4,
  localparam int SEL_W  = $clog2(NUM_PTR)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_a,
  input  logic               wr_b,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic               tog_en,
  output logic [SEL_W-1:0]   sel,
  output logic [NUM_PTR-1:0] dir,
  output logic [BYTE_W-1:0]  ctrl_a,
  output logic [BYTE_W-1:0]  ctrl_b
);
  logic [SEL_W-1:0]   sel_q, sel_d;
  logic [NUM_PTR-1:0] dir_q, dir_d;
  logic               unused_bits;

  assign unused_bits = ^{wr_data[5:4], wr_data[2:1]};

  always_comb begin
    sel_d = sel_q;
    dir_d = dir_q;
    if (wr_a) begin
      sel_d    = {wr_data[SEL1_BIT], wr_data[SEL0_BIT]};
      dir_d[0] = wr_data[DIRL_BIT];
      dir_d[1] = wr_data[DIRH_BIT];
    end else if (wr_b) begin
      dir_d[2] = wr_data[DIRL_BIT];
      dir_d[3] = wr_data[DIRH_BIT];
    end else if (tog_en) begin
      sel_d[0] = ~sel_q[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      dir_q <= '0;
    end else begin
      sel_q <= sel_d;
      dir_q <= dir_d;
    end
  end

  always_comb begin
    ctrl_a = '0;
    ctrl_a[SEL0_BIT] = sel_q[0];
    ctrl_a[SEL1_BIT] = sel_q[1];
    ctrl_a[DIRL_BIT] = dir_q[0];
    ctrl_a[DIRH_BIT] = dir_q[1];
    ctrl_b = '0;
    ctrl_b[DIRL_BIT] = dir_q[2];
    ctrl_b[DIRH_BIT] = dir_q[3];
  end

  assign sel = sel_q;
  assign dir = dir_q;
endmodule

// File: rtl/ptr_rdmux.sv
module ptr_rdmux
  import ptr_unit_pkg::*;
#(
  parameter int NUM_PTR = 4,
  parameter int NBYTES  = 3,
  localparam int PW = BYTE_W*NBYTES
) (
  input  logic [NUM_PTR-1:0][PW-1:0] ptrs,
  input  logic [BYTE_W-1:0]          ctrl_a,
  input  logic [BYTE_W-1:0]          ctrl_b,
  input  logic [REG_AW-1:0]          rd_addr,
  output logic [BYTE_W-1:0]          rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_addr == CTRL_A_ADDR)
      rd_data = ctrl_a;
    else if (rd_addr == CTRL_B_ADDR)
      rd_data = ctrl_b;
    else if (!rd_addr[4] && (int'(rd_addr[1:0]) < NBYTES))
      rd_data = ptrs[rd_addr[3:2]][int'(rd_addr[1:0])*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/ptr_unit.sv
module ptr_unit
  import ptr_unit_pkg::*;
#(
  parameter int NUM_PTR = 4,
  parameter int NBYTES  = 3,
  localparam int PW    = BYTE_W*NBYTES,
  localparam int SEL_W = $clog2(NUM_PTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              step_stb,
  input  logic              tog_stb,
  input  logic              wide_mode,
  output logic [PW-1:0]     mem_addr
);
  // reset: asserted at once, released on the clock
  logic rst_m_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m_q    <= 1'b1;
      rst_sync_n <= rst_m_q;
    end
  end

  logic                      step_go, tog_go, wr_a, wr_b, ptr_wr;
  logic [SEL_W-1:0]          sel_q;
  logic [NUM_PTR-1:0]        dir_q;
  logic [BYTE_W-1:0]         ctrl_a, ctrl_b;
  logic [NUM_PTR-1:0][PW-1:0] ptrs;
  logic [PW-1:0]             act_ptr;
  logic                      act_dir;

  assign step_go = step_stb & ~wr_en;
  assign tog_go  = tog_stb  & ~wr_en;
  assign wr_a    = wr_en & (wr_addr == CTRL_A_ADDR);
  assign wr_b    = wr_en & (wr_addr == CTRL_B_ADDR);
  assign ptr_wr  = wr_en & ~wr_addr[4] & (int'(wr_addr[1:0]) < NBYTES);

  ptr_ctrl #(.NUM_PTR(NUM_PTR)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .wr_a(wr_a), .wr_b(wr_b),
    .wr_data(wr_data), .tog_en(tog_go), .sel(sel_q), .dir(dir_q),
    .ctrl_a(ctrl_a), .ctrl_b(ctrl_b)
  );

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_slot
    ptr_slot #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .LOW_BYTES(2)) u_slot (
      .clk(clk), .rst_n(rst_sync_n),
      .wr_en(ptr_wr && (int'(wr_addr[3:2]) == g)),
      .wr_byte(wr_addr[1:0]),
      .wr_data(wr_data),
      .step_en(step_go && (int'(sel_q) == g)),
      .dir_dn(dir_q[g]),
      .wide(wide_mode),
      .value(ptrs[g])
    );
  end

  ptr_rdmux #(.NUM_PTR(NUM_PTR), .NBYTES(NBYTES)) u_rd (
    .ptrs(ptrs), .ctrl_a(ctrl_a), .ctrl_b(ctrl_b),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign act_ptr  = ptrs[sel_q];
  assign act_dir  = dir_q[sel_q];
  assign mem_addr = wide_mode ? act_ptr : {{(PW-16){1'b0}}, act_ptr[15:0]};
endmodule

// File: rtl/ptr_unit_chk.sv
module ptr_unit_chk
  import ptr_unit_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr,
  input logic              step_stb,
  input logic              tog_stb,
  input logic              wide_mode,
  input logic [1:0]        sel_q,
  input logic [23:0]       act_ptr,
  input logic              act_dir
);
  // R4
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_stb && !wr_en && !tog_stb && wide_mode && !act_dir |=> act_ptr == $past(act_ptr) + 24'd1);
  // R5
  step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_stb && !wr_en && !tog_stb && wide_mode && act_dir |=> act_ptr == $past(act_ptr) - 24'd1);
  // R6
  narrow_ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_stb && !wr_en && !tog_stb && !wide_mode |=> act_ptr[23:16] == $past(act_ptr[23:16]));
  // R8
  toggle_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tog_stb && !wr_en |=> sel_q == {$past(sel_q[1]), ~$past(sel_q[0])});
  // R9
  write_blocks_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_addr != CTRL_A_ADDR) |=> $stable(sel_q));
endmodule

bind ptr_unit ptr_unit_chk i_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .step_stb(step_stb), .tog_stb(tog_stb), .wide_mode(wide_mode),
  .sel_q(sel_q), .act_ptr(act_ptr), .act_dir(act_dir)
);

// File: tb/test_ptr_unit.sv
`timescale 1ns/1ps
module test_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, step_stb, tog_stb, wide_mode;
  logic [4:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data, rd_data;
  logic [23:0] mem_addr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ptr_unit i_ptr_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .step_stb(step_stb), .tog_stb(tog_stb),
    .wide_mode(wide_mode), .mem_addr(mem_addr)
  );

  // op codes: 0 write, 1 step, 2 toggle, 3 idle
  // entry = {op[1:0], addr[4:0], data[7:0], wide, expected mem_addr[23:0]}
  localparam int NV = 28;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 5'h00, 8'hFF, 1'b1, 24'h0000FF},
    {2'd0, 5'h01, 8'hFF, 1'b1, 24'h00FFFF},
    {2'd1, 5'h00, 8'h00, 1'b1, 24'h010000},  // R4 carry
    {2'd0, 5'h02, 8'hFF, 1'b1, 24'hFF0000},
    {2'd0, 5'h01, 8'hFF, 1'b1, 24'hFFFF00},
    {2'd0, 5'h00, 8'hFF, 1'b1, 24'hFFFFFF},
    {2'd1, 5'h00, 8'h00, 1'b1, 24'h000000},  // R4 wrap
    {2'd0, 5'h10, 8'h40, 1'b1, 24'h000000},  // R7 dir0
    {2'd1, 5'h00, 8'h00, 1'b1, 24'hFFFFFF},  // R5 borrow wrap
    {2'd0, 5'h06, 8'h12, 1'b1, 24'hFFFFFF},
    {2'd0, 5'h05, 8'h34, 1'b1, 24'hFFFFFF},
    {2'd0, 5'h04, 8'h00, 1'b1, 24'hFFFFFF},
    {2'd2, 5'h00, 8'h00, 1'b1, 24'h123400},  // R8 0->1
    {2'd1, 5'h00, 8'h00, 1'b1, 24'h123401},  // R4 own direction
    {2'd2, 5'h00, 8'h00, 1'b1, 24'hFFFFFF},  // R8 1->0
    {2'd0, 5'h10, 8'h08, 1'b1, 24'h000000},  // R7 select bit 1
    {2'd0, 5'h11, 8'h40, 1'b1, 24'h000000},  // R7 dir2
    {2'd1, 5'h00, 8'h00, 1'b1, 24'hFFFFFF},  // R5
    {2'd2, 5'h00, 8'h00, 1'b1, 24'h000000},  // R8 2->3
    {2'd1, 5'h00, 8'h00, 1'b1, 24'h000001},  // R4
    {2'd2, 5'h00, 8'h00, 1'b1, 24'hFFFFFF},  // R8 3->2
    {2'd0, 5'h0A, 8'h12, 1'b0, 24'h00FFFF},  // R3 narrow
    {2'd0, 5'h09, 8'h00, 1'b0, 24'h0000FF},
    {2'd0, 5'h08, 8'h00, 1'b0, 24'h000000},
    {2'd1, 5'h00, 8'h00, 1'b0, 24'h00FFFF},  // R6 16-bit borrow
    {2'd0, 5'h11, 8'h00, 1'b0, 24'h00FFFF},
    {2'd1, 5'h00, 8'h00, 1'b0, 24'h000000},  // R6 16-bit carry
    {2'd3, 5'h00, 8'h00, 1'b1, 24'h120000}   // R3 wide, R6 extension kept
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %06h expected %06h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(req, {16'h0, rd_data}, {16'h0, exp});
  endtask

  task automatic cyc(input logic w, input logic [4:0] a, input logic [7:0] d,
                     input logic s, input logic t);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; step_stb = s; tog_stb = t;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; step_stb = 1'b0; tog_stb = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    step_stb = 0; tog_stb = 0; wide_mode = 1;
    do_reset();
    chk("R1 mem_addr", mem_addr, 24'h0);
    rd_chk("R1 ctrl A", 5'h10, 8'h00);
    rd_chk("R1 ctrl B", 5'h11, 8'h00);
    rd_chk("R1 ptr0 low", 5'h00, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][39:38];
      @(negedge clk);
      wide_mode = VEC[i][24];
      cyc(op == 2'd0, VEC[i][37:33], VEC[i][32:25], op == 2'd1, op == 2'd2);
      chk($sformatf("R3/R4/R5/R6/R8 vector %0d", i), mem_addr, VEC[i][23:0]);
    end

    rd_chk("R6 extension byte kept", 5'h0A, 8'h12);
    rd_chk("R7 ctrl A readback", 5'h10, 8'h08);
    rd_chk("R7 ctrl B readback", 5'h11, 8'h00);

    // R9 write wins over step (same pointer)
    cyc(1'b1, 5'h08, 8'h55, 1'b1, 1'b0);
    chk("R9 write beats step", mem_addr, 24'h120055);
    // R9 write elsewhere still blocks step
    cyc(1'b1, 5'h00, 8'hAA, 1'b1, 1'b0);
    chk("R9 step blocked", mem_addr, 24'h120055);
    rd_chk("R2 ptr0 low written", 5'h00, 8'hAA);
    // R9 write blocks toggle
    cyc(1'b1, 5'h05, 8'h01, 1'b0, 1'b1);
    chk("R9 toggle blocked", mem_addr, 24'h120055);
    // R10 step and toggle together
    cyc(1'b0, 5'h00, 8'h00, 1'b1, 1'b1);
    chk("R10 new active ptr3", mem_addr, 24'h000001);
    cyc(1'b0, 5'h00, 8'h00, 1'b0, 1'b1);
    chk("R10 old ptr2 stepped", mem_addr, 24'h120056);

    // R7 unused control bits
    cyc(1'b1, 5'h10, 8'hFF, 1'b0, 1'b0);
    rd_chk("R7 ctrl A mask", 5'h10, 8'hC9);
    chk("R7 sel=3", mem_addr, 24'h000001);
    cyc(1'b1, 5'h11, 8'hFF, 1'b0, 1'b0);
    rd_chk("R7 ctrl B mask", 5'h11, 8'hC0);

    // R2 holes
    cyc(1'b1, 5'h03, 8'h77, 1'b0, 1'b0);
    rd_chk("R2 byte code 3", 5'h03, 8'h00);
    cyc(1'b1, 5'h15, 8'h77, 1'b0, 1'b0);
    rd_chk("R2 unused address", 5'h15, 8'h00);
    rd_chk("R2 ptr0 low intact", 5'h00, 8'hAA);
    rd_chk("R2 ptr3 low", 5'h0C, 8'h01);
    rd_chk("R2 ptr1 high", 5'h05, 8'h01);

    // R1 reset in mid-run
    do_reset();
    chk("R1 mem_addr after reset", mem_addr, 24'h0);
    rd_chk("R1 ctrl A after reset", 5'h10, 8'h00);
    rd_chk("R1 ctrl B after reset", 5'h11, 8'h00);
    rd_chk("R1 ptr2 ext after reset", 5'h0A, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule